// File: doc/BRIEF.md
# Radix-4 Word-Serial Montgomery Processing Element

This block is one processing element of a word-serial radix-4 Montgomery multiplier. The running result is held in redundant form, as a carry vector and a sum vector. One outer-loop step streams through the element one W-bit word per clock, least significant word first. Each step adds a signed multiple of the multiplicand A, chosen by a recoded digit of B, and a signed multiple of the odd modulus M. It then divides the total by four, by shifting both vectors right by two bit positions.

The multiplier digit comes from three consecutive bits of B. The element picks the quotient digit on word 0 so that the low two bits of the running total cancel. That quotient is then held for the remaining words of the step. A two-bit right shift needs the low bits of the next word, so each result word leaves the element one clock after the word above it arrives. The top word leaves one clock later again, with both vectors sign-extended. One bit that the shift would lose on word 0 comes out as a loop carry, which is fed back as the loop-carry input of the next step. Outer-loop sequencing, intermediate buffering and the final correction belong to the surrounding datapath.

A step must contain at least two words. The caller marks the first and last word of each step. M must be odd.

Top module: `pe4_word_slice`

## Requirements
- R1: The multiplier digit is decoded from `in_bdig` = {b(2i+1), b(2i), b(2i-1)} on the first word. It has the value -2·bit2 + bit1 + bit0, so 000 and 111 give 0, 001 and 010 give +1, 011 gives +2, 100 gives -2, and 101 and 110 give -1. It is reported on `out_beta` as a 3-bit two's-complement value from the clock after the first word.
- R2: The quotient digit is the one value q in {-1, 0, 1, 2} for which (s + q·M) mod 4 = 0, where s = (TC + TS + loop_in + β·A) mod 4. It is reported on `out_q` as a 3-bit two's-complement value from the clock after the first word.
- R3: `out_loop` reports the carry into bit 2 that is lost when the low two bits of the word-0 result vectors are dropped. When the total is exactly zero and the low bits of the carry and sum vectors are 10 and 10, this bit is 1. When every operand is zero, it is 0.
- R4: For a step of E words (N = E·W bits), the following holds modulo 2^(N-2): (output carry vector) + (output sum vector) + `out_loop` = (TC + TS + loop_in + β·A + q·M mod 2^N) / 4.
- R5: The output word j-1 is valid one clock after input word j is accepted. The top output word is valid one clock after that, and only it carries `out_last` = 1.
- R6: On the top output word, bits W-1 and W-2 of `out_tc` and of `out_ts` each equal bit W-3 of the same vector.
- R7: Carries out of the top word of a step do not reach word 0 of the next step.
- R8: A multiplier digit of magnitude 2 shifts A left across word boundaries. Bit 0 of word j of 2A is bit W-1 of word j-1 of A, and bit 0 of word 0 is zero.
- R9: While reset is held, `out_valid`, `out_last`, `out_beta`, `out_q` and `out_loop` are all zero.
- R10: A new step may start on the clock right after the last word of the previous step, and both steps still meet R4.
- R11: Clocks with `in_valid` low inside a step change nothing, and the step still meets R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Word present on the inputs this clock |
| in_first | input | 1 | Word 0 of a step |
| in_last | input | 1 | Top word of a step |
| in_a | input | W | Multiplicand word |
| in_m | input | W | Modulus word (odd modulus) |
| in_tc | input | W | Carry vector word of the running result |
| in_ts | input | W | Sum vector word of the running result |
| in_bdig | input | 3 | Three bits of B for this step, sampled on word 0 |
| in_loop | input | 1 | Loop carry from the previous step, sampled on word 0 |
| out_valid | output | 1 | Result word present |
| out_last | output | 1 | Result word is the top word |
| out_tc | output | W | Shifted carry vector word |
| out_ts | output | W | Shifted sum vector word |
| out_beta | output | 3 | Multiplier digit of the current step |
| out_q | output | 3 | Quotient digit of the current step |
| out_loop | output | 1 | Loop carry produced on word 0 |

## Verification
The bench builds the element with W = 8 and runs four-word steps, so N = 32. At that size the exact reference sum fits in a 64-bit integer, and the mod 2^30 comparison can be made directly. Four words give three internal word boundaries, which is enough to see 2A bits and carry-save carries crossing words. Each step is short enough that all eight multiplier codes, both residues of M mod 4, back-to-back steps and steps with idle clocks all fit in a few hundred clocks.

// File: rtl/pe4_pkg.sv
package pe4_pkg;

  typedef logic signed [2:0] digit_t;

  // Multiplier digit from {b(2i+1), b(2i), b(2i-1)}
  function automatic digit_t booth_digit(input logic [2:0] b);
    digit_t d;
    case (b)
      3'b001, 3'b010: d = 3'sb001;
      3'b011:         d = 3'sb010;
      3'b100:         d = 3'sb110;
      3'b101, 3'b110: d = 3'sb111;
      default:        d = 3'sb000;
    endcase
    return d;
  endfunction

  // Quotient digit in [-1,2] from modulus bit 1 and the low residue s
  function automatic digit_t quot_digit(input logic m1, input logic [1:0] s);
    digit_t q;
    case ({m1, s})
      3'b001, 3'b111: q = 3'sb111;
      3'b010, 3'b110: q = 3'sb010;
      3'b011, 3'b101: q = 3'sb001;
      default:        q = 3'sb000;
    endcase
    return q;
  endfunction

  // Magnitude code of a signed digit: 0, 1 or 2
  function automatic logic [1:0] digit_mag(input digit_t d);
    logic [2:0] a;
    a = d[2] ? (~d + 3'd1) : d;
    return a[1:0];
  endfunction

endpackage

// File: rtl/pe4_multiple.sv
module pe4_multiple
  import pe4_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] word,
  input  logic         prev_msb,
  input  digit_t       d,
  output logic [W-1:0] mult
);
  logic [W-1:0] doubled;
  logic [W-1:0] mag;
  logic [1:0]   mcode;

  // R8: the doubled word borrows the top bit of the word below
  assign doubled = {word[W-2:0], prev_msb};
  assign mcode   = digit_mag(d);

  always_comb begin
    case (mcode)
      2'd1:    mag = word;
      2'd2:    mag = doubled;
      default: mag = '0;
    endcase
    mult = d[2] ? ~mag : mag;
  end
endmodule

// File: rtl/pe4_csa.sv
module pe4_csa #(
  parameter int W = 16
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic [W-1:0] z,
  input  logic         cin,
  output logic [W-1:0] carry_vec,
  output logic [W-1:0] sum_vec,
  output logic         cout
);
  logic [W-1:0] maj;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign sum_vec[i] = x[i] ^ y[i] ^ z[i];
    assign maj[i]     = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
  end

  assign carry_vec = {maj[W-2:0], cin};
  assign cout      = maj[W-1];
endmodule

// File: rtl/pe4_quot_sel.sv
module pe4_quot_sel
  import pe4_pkg::*;
(
  input  logic [1:0] c_low,
  input  logic [1:0] s_low,
  input  logic       loop_in,
  input  logic       m_bit1,
  output logic [1:0] resid,
  output digit_t     q
);
  assign resid = c_low + s_low + {1'b0, loop_in};
  assign q     = quot_digit(m_bit1, resid);
endmodule

// File: rtl/pe4_word_slice.sv
module pe4_word_slice
  import pe4_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic         in_first,
  input  logic         in_last,
  input  logic [W-1:0] in_a,
  input  logic [W-1:0] in_m,
  input  logic [W-1:0] in_tc,
  input  logic [W-1:0] in_ts,
  input  logic [2:0]   in_bdig,
  input  logic         in_loop,
  output logic         out_valid,
  output logic         out_last,
  output logic [W-1:0] out_tc,
  output logic [W-1:0] out_ts,
  output logic [2:0]   out_beta,
  output logic [2:0]   out_q,
  output logic         out_loop
);
  localparam int SHIFT = 2;
  localparam int KEEP  = W - SHIFT;

  // Held per step
  digit_t beta_q, q_q;
  logic   a_msb_q, m_msb_q, c1_q, c2_q;
  logic   tail_pend;
  logic [W-1:SHIFT] prev_c, prev_s;

  // Named internal events
  digit_t       beta_now, q_sel, q_now;
  logic         beta_neg, a_prev, m_prev, cin1, cin2, cout1, cout2;
  logic [W-1:0] ba_word, qm_raw, qm_word;
  logic [W-1:0] carry1, sum1, carry2, sum2;
  logic [1:0]   s_low;
  logic         loop_gen;
  logic         word_emit, tail_emit, first_acc;

  assign beta_now = in_first ? booth_digit(in_bdig) : beta_q;
  assign beta_neg = beta_now[2];
  assign a_prev   = in_first ? 1'b0 : a_msb_q;
  assign m_prev   = in_first ? 1'b0 : m_msb_q;

  pe4_multiple #(.W(W)) u_amul (
    .word(in_a), .prev_msb(a_prev), .d(beta_now), .mult(ba_word)
  );

  // Stage 1: running result plus the multiplicand multiple; the +1 of a
  // negated multiple enters on the free carry slot of word 0
  assign cin1 = in_first ? beta_neg : c1_q;

  pe4_csa #(.W(W)) u_csa1 (
    .x(in_tc), .y(in_ts), .z(ba_word), .cin(cin1),
    .carry_vec(carry1), .sum_vec(sum1), .cout(cout1)
  );

  pe4_quot_sel u_qsel (
    .c_low(carry1[1:0]), .s_low(sum1[1:0]), .loop_in(in_loop),
    .m_bit1(in_m[1]), .resid(s_low), .q(q_sel)
  );

  assign q_now = in_first ? q_sel : q_q;

  pe4_multiple #(.W(W)) u_mmul (
    .word(in_m), .prev_msb(m_prev), .d(q_now), .mult(qm_raw)
  );

  // -M on word 0: the inverted odd modulus has bit 0 clear, so the +1 sets it
  assign qm_word = (in_first && q_now == 3'sb111) ? {qm_raw[W-1:1], 1'b1} : qm_raw;

  // Stage 2: add the modulus multiple; loop carry enters on word 0
  assign cin2 = in_first ? in_loop : c2_q;

  pe4_csa #(.W(W)) u_csa2 (
    .x(carry1), .y(sum1), .z(qm_word), .cin(cin2),
    .carry_vec(carry2), .sum_vec(sum2), .cout(cout2)
  );

  assign loop_gen  = carry2[1] | sum2[1];
  assign first_acc = in_valid && in_first;
  assign word_emit = in_valid && !in_first;
  assign tail_emit = tail_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      beta_q    <= '0;
      q_q       <= '0;
      a_msb_q   <= 1'b0;
      m_msb_q   <= 1'b0;
      c1_q      <= 1'b0;
      c2_q      <= 1'b0;
      tail_pend <= 1'b0;
      prev_c    <= '0;
      prev_s    <= '0;
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_tc    <= '0;
      out_ts    <= '0;
      out_beta  <= '0;
      out_q     <= '0;
      out_loop  <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      if (tail_emit) begin
        out_valid <= 1'b1;
        out_last  <= 1'b1;
        out_tc    <= {{SHIFT{prev_c[W-1]}}, prev_c};
        out_ts    <= {{SHIFT{prev_s[W-1]}}, prev_s};
      end else if (word_emit) begin
        out_valid <= 1'b1;
        out_tc    <= {carry2[SHIFT-1:0], prev_c};
        out_ts    <= {sum2[SHIFT-1:0], prev_s};
      end
      tail_pend <= in_valid && in_last;
      if (in_valid) begin
        beta_q  <= beta_now;
        q_q     <= q_now;
        a_msb_q <= in_a[W-1];
        m_msb_q <= in_m[W-1];
        c1_q    <= cout1;
        c2_q    <= cout2;
        prev_c  <= carry2[W-1:SHIFT];
        prev_s  <= sum2[W-1:SHIFT];
      end
      if (first_acc) begin
        out_beta <= beta_now;
        out_q    <= q_sel;
        out_loop <= loop_gen;
      end
    end
  end

  // Checking-only views
  logic [1:0] q_prod, q_resid;
  logic [2:0] low_total;
  assign q_prod    = q_sel[1:0] * in_m[1:0];
  assign q_resid   = s_low + q_prod;
  assign low_total = {1'b0, carry2[1:0]} + {1'b0, sum2[1:0]};

  // R1
  beta_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_acc && beta_neg |-> in_bdig[2]);

  // R2
  quot_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_acc |-> q_resid == 2'b00);

  // R2
  quot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_acc |-> !(q_sel inside {3'sb011, 3'sb100, 3'sb101, 3'sb110}));

  // R3
  loop_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    first_acc |-> (low_total == 3'd0 || low_total == 3'd4) && loop_gen == low_total[2]);

  // R5
  word_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_emit && !tail_pend |=> out_valid && !out_last);

  // R5
  tail_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_last |-> ##2 (out_valid && out_last));

  // R6
  tail_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_last |-> out_tc[W-1] == out_tc[W-3] && out_tc[W-2] == out_tc[W-3]
                           && out_ts[W-1] == out_ts[W-3] && out_ts[W-2] == out_ts[W-3]);

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(beta_q) && $stable(q_q) && $stable(prev_c) && $stable(prev_s));

  initial begin
    assert (KEEP >= 2) else $error("word width too small");
  end
endmodule

// File: tb/pe4_word_slice_test.sv
`timescale 1ns/1ps
module pe4_word_slice_test;
  localparam int W  = 8;
  localparam int E  = 4;
  localparam int NB = W * E;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_loop = 1'b0;
  logic [W-1:0] in_a = '0, in_m = '0, in_tc = '0, in_ts = '0;
  logic [2:0] in_bdig = '0;
  logic out_valid, out_last, out_loop;
  logic [W-1:0] out_tc, out_ts;
  logic [2:0] out_beta, out_q;

  always #10 clk = ~clk;

  pe4_word_slice #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
    .in_last(in_last), .in_a(in_a), .in_m(in_m), .in_tc(in_tc), .in_ts(in_ts),
    .in_bdig(in_bdig), .in_loop(in_loop), .out_valid(out_valid),
    .out_last(out_last), .out_tc(out_tc), .out_ts(out_ts),
    .out_beta(out_beta), .out_q(out_q), .out_loop(out_loop)
  );

  int nchecks = 0;
  int nerr = 0;
  bit done = 1'b0;

  // Step data and collected results
  logic [NB-1:0] pa_tc[4], pa_ts[4], pa_a[4], pa_m[4];
  logic [2:0]    pa_dig[4];
  logic          pa_loop[4];
  logic [NB-1:0] g_tc[4], g_ts[4];
  logic [2:0]    g_beta[4], g_q[4];
  logic          g_loop[4];
  bit            lastbad[4];
  int op, ow, stepno, last_drive, cap_p;
  bit cap_pend;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    nchecks++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  task automatic sample();
    if (cap_pend) begin
      g_beta[cap_p] = out_beta;
      g_q[cap_p]    = out_q;
      g_loop[cap_p] = out_loop;
      cap_pend = 1'b0;
    end
    if (out_valid) begin
      g_tc[op][W*ow +: W] = out_tc;
      g_ts[op][W*ow +: W] = out_ts;
      if (out_last != (ow == E-1)) lastbad[op] = 1'b1;
      if (out_last) chk(stepno - last_drive == 2, "R5", "tail delay", stepno - last_drive, 2);
      ow++;
      if (ow == E) begin op++; ow = 0; end
    end
  endtask

  task automatic step();
    @(negedge clk);
    stepno++;
    sample();
  endtask

  task automatic idle();
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0;
  endtask

  task automatic drive_word(input int p, input int j);
    in_valid = 1'b1;
    in_first = (j == 0);
    in_last  = (j == E-1);
    in_a  = pa_a[p][W*j +: W];
    in_m  = pa_m[p][W*j +: W];
    in_tc = pa_tc[p][W*j +: W];
    in_ts = pa_ts[p][W*j +: W];
    in_bdig = pa_dig[p];
    in_loop = pa_loop[p];
    if (j == 0) begin cap_pend = 1'b1; cap_p = p; end
    if (j == E-1) last_drive = stepno;
  endtask

  task automatic set_pass(input int p, input logic [NB-1:0] tc, input logic [NB-1:0] ts,
                          input logic [NB-1:0] a, input logic [NB-1:0] m,
                          input logic [2:0] d, input logic lp);
    pa_tc[p] = tc; pa_ts[p] = ts; pa_a[p] = a; pa_m[p] = m | 1;
    pa_dig[p] = d; pa_loop[p] = lp;
  endtask

  task automatic verify_pass(input int p, input string tag);
    longint beta, s, q, r, rexp, got, mv;
    beta = -2 * longint'(pa_dig[p][2]) + longint'(pa_dig[p][1]) + longint'(pa_dig[p][0]);
    chk(longint'($signed(g_beta[p])) == beta, "R1", {tag, " beta"}, $signed(g_beta[p]), beta);
    mv = longint'(pa_m[p]);
    s = (longint'(pa_tc[p]) + longint'(pa_ts[p]) + longint'(pa_loop[p]) + beta * longint'(pa_a[p])) & 3;
    q = 0;
    for (int qq = -1; qq <= 2; qq++)
      if (((s + qq * mv) & 3) == 0) q = qq;
    chk(longint'($signed(g_q[p])) == q, "R2", {tag, " quotient"}, $signed(g_q[p]), q);
    r = longint'(pa_tc[p]) + longint'(pa_ts[p]) + longint'(pa_loop[p])
        + beta * longint'(pa_a[p]) + q * mv;
    rexp = ((r & 64'hFFFF_FFFF) >> 2) & 64'h3FFF_FFFF;
    got = (longint'(g_tc[p]) + longint'(g_ts[p]) + longint'(g_loop[p])) & 64'h3FFF_FFFF;
    chk(got == rexp, "R4", {tag, " shifted sum"}, got, rexp);
    chk(g_tc[p][NB-1] == g_tc[p][NB-3] && g_tc[p][NB-2] == g_tc[p][NB-3] &&
        g_ts[p][NB-1] == g_ts[p][NB-3] && g_ts[p][NB-2] == g_ts[p][NB-3],
        "R6", {tag, " tail sign bits"}, {g_tc[p][NB-1:NB-3], g_ts[p][NB-1:NB-3]}, 0);
    chk(!lastbad[p], "R5", {tag, " last marker"}, lastbad[p], 0);
  endtask

  task automatic run_stream(input int np, input bit gap, input string tag);
    op = 0; ow = 0;
    for (int p = 0; p < 4; p++) lastbad[p] = 1'b0;
    for (int p = 0; p < np; p++)
      for (int j = 0; j < E; j++) begin
        if (gap && j == 2) begin step(); idle(); end
        step();
        drive_word(p, j);
      end
    repeat (4) begin step(); idle(); end
    chk(op == np, "R5", {tag, " steps collected"}, op, np);
    for (int p = 0; p < np; p++) verify_pass(p, tag);
  endtask

  function automatic logic [NB-1:0] rnd();
    return NB'($urandom());
  endfunction

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && out_last == 0, "R9", "reset valid/last", {out_valid, out_last}, 0);
    chk(out_beta == 0 && out_q == 0 && out_loop == 0, "R9", "reset digits",
        {out_beta, out_q, out_loop}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_booth_codes();
    for (int d = 0; d < 8; d++) begin
      set_pass(0, rnd(), rnd(), rnd(), rnd(), 3'(d), 1'($urandom()));
      run_stream(1, 1'b0, "R1 code");
    end
  endtask

  task automatic t_quot_cover();
    for (int k = 0; k < 16; k++) begin
      logic [NB-1:0] m;
      m = rnd();
      m[1:0] = (k % 2 == 0) ? 2'b01 : 2'b11;
      set_pass(0, rnd(), rnd(), rnd(), m, 3'(k / 2), 1'(k / 4));
      run_stream(1, 1'b0, "R2 cover");
    end
  endtask

  task automatic t_boundary();
    set_pass(0, '0, '0, 32'h8080_8080, 32'h1357_9BDF, 3'b011, 1'b0);
    run_stream(1, 1'b0, "R8 plus2");
    set_pass(0, '0, '0, 32'h80FF_0180, 32'h2468_ACE1, 3'b100, 1'b0);
    run_stream(1, 1'b0, "R8 minus2");
  endtask

  task automatic t_loop();
    set_pass(0, 32'd1, '0, '0, 32'd1, 3'b000, 1'b0);
    run_stream(1, 1'b0, "R3 lost bit");
    chk(g_loop[0] == 1'b1, "R3", "loop carry set", g_loop[0], 1);
    set_pass(0, '0, '0, '0, 32'd1, 3'b000, 1'b0);
    run_stream(1, 1'b0, "R3 zero");
    chk(g_loop[0] == 1'b0, "R3", "loop carry clear", g_loop[0], 0);
  endtask

  task automatic t_back_to_back();
    // R7: first step drives carries out of its top word
    set_pass(0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011, 1'b1);
    set_pass(1, 32'h0000_0005, 32'h0000_0003, 32'h0000_0011, 32'h0000_0007, 3'b001, 1'b0);
    run_stream(2, 1'b0, "R7 R10 b2b");
    set_pass(0, rnd(), rnd(), rnd(), rnd(), 3'b110, 1'b1);
    set_pass(1, rnd(), rnd(), rnd(), rnd(), 3'b010, 1'b0);
    run_stream(2, 1'b0, "R10 b2b");
  endtask

  task automatic t_gaps();
    set_pass(0, rnd(), rnd(), rnd(), rnd(), 3'b101, 1'b0);
    set_pass(1, rnd(), rnd(), rnd(), rnd(), 3'b011, 1'b1);
    run_stream(2, 1'b1, "R11 gaps");
  endtask

  initial begin
    stepno = 0; last_drive = 0; cap_pend = 1'b0; cap_p = 0; op = 0; ow = 0;
    t_reset();
    t_booth_codes();
    t_quot_cover();
    t_boundary();
    t_loop();
    t_back_to_back();
    t_gaps();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchecks++;
      nerr++;
      $display("FAIL watchdog: actual %0d expected %0d", 20000, 0);
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  end
endmodule